// File: doc/BRIEF.md
# NAND Page Read Pointer and Column Counter

This block holds the read-side addressing of a NAND device whose pages are 528 bytes long: 512 main bytes followed by 16 spare bytes. Three pointer commands choose the region where a read starts. The first half of the main area covers bytes 0 to 255, the second half covers bytes 256 to 511, and the spare area covers bytes 512 to 527. Three address cycles then give the starting column within that region and the page number.

After the last address cycle the block goes busy and requests the page from an array model. The array model returns the 528 bytes one per cycle, and the block writes them into its own page register. When the page is loaded, busy drops and the byte at the start column appears on the output. Each read strobe moves the column forward by one. At the last column the block selects the next page and loads it automatically. In spare mode this next load starts again at byte 512, so the spare bytes of successive pages are read one page after another.

All control inputs are single-cycle strobes synchronous to `clk`, and each stands for one latch event on the device pins.

Top module: `nand_rd_pointer`

## Requirements
- R1: A command byte accepted while `ce_n` is low and `busy` is low sets `rd_ptr` as follows: 0x00 gives 0 (first main half), 0x01 gives 1 (second main half), 0x50 gives 2 (spare). Any other code is ignored, and every command is ignored while `ce_n` is high or `busy` is high.
- R2: The first address cycle gives the column byte B, the second gives page bits 7:0 and the third gives page bits 15:8. The start column is B in region 0 and 256+B in region 1.
- R3: In region 2 the start column is 512 + B[3:0]. Bits 7:4 of B have no effect.
- R4: In the cycle after the third address cycle, `busy` and `fetch_req` are high and `fetch_page` holds the addressed page. They stay high until the 528th `fill_valid` byte is taken. In the next cycle `dout_valid` is high and `dout` is the byte at the start column. Read strobes given while busy change nothing.
- R5: Each `re_pulse` while streaming with `ce_n` low moves to the next byte: `rd_col` goes up by one and `dout` shows that byte in the next cycle.
- R6: The last column is 511 when `spare_off` is high during a main-area read, and 527 in every other case. A strobe at the last column increments the page, sets the column to 0 (main) or 512 (spare) and starts a new load.
- R7: Region 2 stays selected across page changes and across new address sequences. Only a 0x00 or 0x01 command leaves it.
- R8: Region 1 is used once. After the third address cycle of a read started in region 1, `rd_ptr` reads 0.
- R9: Moving on from page 0xFFFF selects page 0.
- R10: With `ce_n` high during streaming, `dout_valid` goes low in the next cycle and later read strobes change nothing. A new address sequence is needed to read again, and no command has to be issued again before it.
- R11: After reset, `rd_ptr` is 0, and `busy`, `fetch_req` and `dout_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| cmd_we | input | 1 | Command latch strobe |
| cmd_byte | input | 8 | Command code |
| addr_we | input | 1 | Address latch strobe |
| addr_byte | input | 8 | Address byte |
| re_pulse | input | 1 | Read strobe, one per output byte |
| spare_off | input | 1 | High: main-area reads end at column 511 |
| fetch_req | output | 1 | Page load request to the array model |
| fetch_page | output | PAGE_W | Page being requested |
| fill_valid | input | 1 | Array model byte valid |
| fill_data | input | DATA_W | Array model byte, in column order from 0 |
| busy | output | 1 | Page load in progress |
| dout_valid | output | 1 | Streaming, `dout` valid |
| dout | output | DATA_W | Byte at the current column |
| rd_ptr | output | 2 | Current pointer region |
| rd_col | output | 10 | Current column |
| rd_page | output | PAGE_W | Current page |

## Verification
The assertions rely on the inputs following a few rules. Every strobe lasts exactly one cycle. A command and an address byte never arrive together. `spare_off` does not change while a main-area read is close to column 511. The array model sends bytes only while `fetch_req` is high. The stimulus meets these rules by driving every strobe for a single cycle from tasks and by changing `spare_off` only between read sequences. The array model in the bench starts a 528-byte burst only when it sees a request.

// File: rtl/nrp_pkg.sv
package nrp_pkg;

    localparam int HALF_BYTES  = 256;
    localparam int MAIN_BYTES  = 512;
    localparam int SPARE_BYTES = 16;
    localparam int PAGE_BYTES  = MAIN_BYTES + SPARE_BYTES;
    localparam int COL_W       = $clog2(PAGE_BYTES);

    localparam logic [7:0] OP_LOW   = 8'h00;
    localparam logic [7:0] OP_HIGH  = 8'h01;
    localparam logic [7:0] OP_SPARE = 8'h50;

    typedef logic [COL_W-1:0] col_t;

    typedef enum logic [1:0] {
        PTR_LOW   = 2'd0,
        PTR_HIGH  = 2'd1,
        PTR_SPARE = 2'd2
    } ptr_e;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_LOAD   = 2'd1,
        SQ_STREAM = 2'd2
    } seq_e;

    typedef struct packed {
        logic valid;
        ptr_e ptr;
    } ptr_cmd_t;

    typedef struct packed {
        logic spare;
        col_t col;
    } entry_t;

    function automatic ptr_cmd_t decode_op(input logic [7:0] op);
        ptr_cmd_t r;
        r.valid = 1'b1;
        case (op)
            OP_LOW:   r.ptr = PTR_LOW;
            OP_HIGH:  r.ptr = PTR_HIGH;
            OP_SPARE: r.ptr = PTR_SPARE;
            default: begin
                r.valid = 1'b0;
                r.ptr   = PTR_LOW;
            end
        endcase
        return r;
    endfunction

    function automatic col_t entry_col(input ptr_e p, input logic [7:0] b);
        case (p)
            PTR_HIGH:  return col_t'(HALF_BYTES) + col_t'(b);
            PTR_SPARE: return col_t'(MAIN_BYTES) + col_t'(b[3:0]);
            default:   return col_t'(b);
        endcase
    endfunction

    function automatic col_t final_col(input logic spare_pg, input logic main_only);
        if (!spare_pg && main_only)
            return col_t'(MAIN_BYTES - 1);
        return col_t'(PAGE_BYTES - 1);
    endfunction

    function automatic col_t wrap_col(input logic spare_pg);
        return spare_pg ? col_t'(MAIN_BYTES) : col_t'(0);
    endfunction

endpackage

// File: rtl/nrp_addr_capture.sv
module nrp_addr_capture
    import nrp_pkg::*;
#(
    parameter int PAGE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              cmd_we,
    input  logic [7:0]        cmd_byte,
    input  logic              addr_we,
    input  logic [7:0]        addr_byte,
    output ptr_e              ptr,
    output logic              go,
    output entry_t            entry,
    output logic [PAGE_W-1:0] go_page
);

    localparam int RAW_W = 16;

    logic [1:0]       phase;
    logic [7:0]       col_byte;
    logic [7:0]       pg_lo;
    logic [RAW_W-1:0] raw_page;
    ptr_cmd_t         dec;

    always_comb begin
        dec         = decode_op(cmd_byte);
        raw_page    = {addr_byte, pg_lo};
        go_page     = raw_page[PAGE_W-1:0];
        go          = accept && addr_we && !cmd_we && (phase == 2'd2);
        entry.spare = (ptr == PTR_SPARE);
        entry.col   = entry_col(ptr, col_byte);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr      <= PTR_LOW;
            phase    <= 2'd0;
            col_byte <= 8'h00;
            pg_lo    <= 8'h00;
        end else if (accept && cmd_we) begin
            if (dec.valid) begin
                ptr   <= dec.ptr;
                phase <= 2'd0;
            end
        end else if (accept && addr_we) begin
            case (phase)
                2'd0: begin
                    col_byte <= addr_byte;
                    phase    <= 2'd1;
                end
                2'd1: begin
                    pg_lo <= addr_byte;
                    phase <= 2'd2;
                end
                default: begin
                    phase <= 2'd0;
                    if (ptr == PTR_HIGH)
                        ptr <= PTR_LOW;
                end
            endcase
        end
    end

endmodule

// File: rtl/nrp_page_buf.sv
module nrp_page_buf
    import nrp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              loading,
    input  logic              fill_valid,
    input  logic [DATA_W-1:0] fill_data,
    input  col_t              rd_col,
    output logic              fill_done,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [PAGE_BYTES];
    col_t              widx;

    always_ff @(posedge clk) begin
        if (rst)
            widx <= '0;
        else if (!loading)
            widx <= '0;
        else if (fill_valid)
            widx <= widx + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (loading && fill_valid)
            mem[widx] <= fill_data;
    end

    always_comb begin
        fill_done = loading && fill_valid && (widx == col_t'(PAGE_BYTES - 1));
        rd_data   = mem[rd_col];
    end

endmodule

// File: rtl/nrp_seq_ctrl.sv
module nrp_seq_ctrl
    import nrp_pkg::*;
#(
    parameter int PAGE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  entry_t            entry,
    input  logic [PAGE_W-1:0] go_page,
    input  logic              re_pulse,
    input  logic              ce_n,
    input  logic              spare_off,
    input  logic              fill_done,
    output logic              busy,
    output logic              streaming,
    output col_t              col,
    output logic [PAGE_W-1:0] page
);

    seq_e st;
    logic spare_pg;
    col_t last;
    logic at_end;

    always_comb begin
        last      = final_col(spare_pg, spare_off);
        at_end    = (col >= last);
        busy      = (st == SQ_LOAD);
        streaming = (st == SQ_STREAM);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= SQ_IDLE;
            col      <= '0;
            page     <= '0;
            spare_pg <= 1'b0;
        end else begin
            case (st)
                SQ_LOAD: begin
                    if (fill_done)
                        st <= SQ_STREAM;
                end
                default: begin
                    if (go) begin
                        st       <= SQ_LOAD;
                        col      <= entry.col;
                        page     <= go_page;
                        spare_pg <= entry.spare;
                    end else if (st == SQ_STREAM) begin
                        if (ce_n) begin
                            st <= SQ_IDLE;
                        end else if (re_pulse) begin
                            if (at_end) begin
                                col  <= wrap_col(spare_pg);
                                page <= page + 1'b1;
                                st   <= SQ_LOAD;
                            end else begin
                                col <= col + 1'b1;
                            end
                        end
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/nand_rd_pointer.sv
module nand_rd_pointer
    import nrp_pkg::*;
#(
    parameter int PAGE_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              cmd_we,
    input  logic [7:0]        cmd_byte,
    input  logic              addr_we,
    input  logic [7:0]        addr_byte,
    input  logic              re_pulse,
    input  logic              spare_off,
    output logic              fetch_req,
    output logic [PAGE_W-1:0] fetch_page,
    input  logic              fill_valid,
    input  logic [DATA_W-1:0] fill_data,
    output logic              busy,
    output logic              dout_valid,
    output logic [DATA_W-1:0] dout,
    output logic [1:0]        rd_ptr,
    output logic [COL_W-1:0]  rd_col,
    output logic [PAGE_W-1:0] rd_page
);

    ptr_e              ptr;
    logic              go;
    entry_t            entry;
    logic [PAGE_W-1:0] go_page;
    logic              accept;
    logic              fill_done;
    logic [DATA_W-1:0] rd_data;
    col_t              col;
    logic [PAGE_W-1:0] page;
    logic              busy_i;
    logic              stream_i;

    assign accept = !ce_n && !busy_i;

    nrp_addr_capture #(.PAGE_W(PAGE_W)) addr_i (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .cmd_we    (cmd_we),
        .cmd_byte  (cmd_byte),
        .addr_we   (addr_we),
        .addr_byte (addr_byte),
        .ptr       (ptr),
        .go        (go),
        .entry     (entry),
        .go_page   (go_page)
    );

    nrp_seq_ctrl #(.PAGE_W(PAGE_W)) seq_i (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .entry     (entry),
        .go_page   (go_page),
        .re_pulse  (re_pulse),
        .ce_n      (ce_n),
        .spare_off (spare_off),
        .fill_done (fill_done),
        .busy      (busy_i),
        .streaming (stream_i),
        .col       (col),
        .page      (page)
    );

    nrp_page_buf #(.DATA_W(DATA_W)) buf_i (
        .clk        (clk),
        .rst        (rst),
        .loading    (busy_i),
        .fill_valid (fill_valid),
        .fill_data  (fill_data),
        .rd_col     (col),
        .fill_done  (fill_done),
        .rd_data    (rd_data)
    );

    always_comb begin
        busy       = busy_i;
        fetch_req  = busy_i;
        fetch_page = page;
        dout_valid = stream_i;
        dout       = stream_i ? rd_data : '0;
        rd_ptr     = ptr;
        rd_col     = col;
        rd_page    = page;
    end

endmodule

// File: rtl/nrp_checker.sv
module nrp_checker
    import nrp_pkg::*;
#(
    parameter int PAGE_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              ce_n,
    input logic              addr_we,
    input logic              re_pulse,
    input logic              busy,
    input logic              dout_valid,
    input logic [1:0]        rd_ptr,
    input logic [COL_W-1:0]  rd_col,
    input logic [PAGE_W-1:0] rd_page
);

    localparam logic [COL_W-1:0] MAIN_END = COL_W'(MAIN_BYTES - 1);
    localparam logic [COL_W-1:0] PAGE_END = COL_W'(PAGE_BYTES - 1);

    AST_PTR_ENCODED: assert property (@(posedge clk) disable iff (rst)
        rd_ptr != 2'd3);  // R1

    AST_BUSY_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(busy && dout_valid));  // R4

    AST_LOAD_FROZEN: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(rd_col) && $stable(rd_page)));  // R4

    AST_COL_STEP: assert property (@(posedge clk) disable iff (rst)
        (dout_valid && re_pulse && !ce_n && !addr_we && rd_col != MAIN_END && rd_col != PAGE_END)
        |=> (rd_col == $past(rd_col) + 1'b1));  // R5

    AST_COL_RANGE: assert property (@(posedge clk) disable iff (rst)
        dout_valid |-> (rd_col <= PAGE_END));  // R6

    AST_PAGE_ROLL: assert property (@(posedge clk) disable iff (rst)
        (dout_valid && re_pulse && !ce_n && !addr_we && rd_col == PAGE_END)
        |=> (busy && rd_page == $past(rd_page) + 1'b1));  // R9

    AST_CE_ENDS: assert property (@(posedge clk) disable iff (rst)
        (dout_valid && ce_n) |=> !dout_valid);  // R10

endmodule

bind nand_rd_pointer nrp_checker #(.PAGE_W(PAGE_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .ce_n       (ce_n),
    .addr_we    (addr_we),
    .re_pulse   (re_pulse),
    .busy       (busy),
    .dout_valid (dout_valid),
    .rd_ptr     (rd_ptr),
    .rd_col     (rd_col),
    .rd_page    (rd_page)
);

// File: tb/nand_rd_pointer_tb_top.sv
`timescale 1ns/1ps
module nand_rd_pointer_tb_top;

    localparam int PW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          ce_n;
    logic          cmd_we;
    logic [7:0]    cmd_byte;
    logic          addr_we;
    logic [7:0]    addr_byte;
    logic          re_pulse;
    logic          spare_off;
    logic          fetch_req;
    logic [PW-1:0] fetch_page;
    logic          fill_valid;
    logic [7:0]    fill_data;
    logic          busy;
    logic          dout_valid;
    logic [7:0]    dout;
    logic [1:0]    rd_ptr;
    logic [9:0]    rd_col;
    logic [PW-1:0] rd_page;

    nand_rd_pointer #(.PAGE_W(PW), .DATA_W(8)) dut_i (
        .clk(clk), .rst(rst), .ce_n(ce_n), .cmd_we(cmd_we), .cmd_byte(cmd_byte),
        .addr_we(addr_we), .addr_byte(addr_byte), .re_pulse(re_pulse),
        .spare_off(spare_off), .fetch_req(fetch_req), .fetch_page(fetch_page),
        .fill_valid(fill_valid), .fill_data(fill_data), .busy(busy),
        .dout_valid(dout_valid), .dout(dout), .rd_ptr(rd_ptr), .rd_col(rd_col),
        .rd_page(rd_page)
    );

    always #4 clk = ~clk;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int m_ptr = 0;
    int m_page = 0;
    int m_col = 0;
    bit m_spare = 1'b0;
    bit so = 1'b0;

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int pg, input int c);
        return 8'((pg * 29) ^ (c * 7) ^ (c >> 5));
    endfunction

    function automatic int m_start(input int p, input int b);
        if (p == 1) return 256 + b;
        if (p == 2) return 512 + (b & 15);
        return b;
    endfunction

    function automatic int m_last(input bit sp, input bit s_off);
        if (!sp && s_off) return 511;
        return 527;
    endfunction

    // array model: one 528-byte burst per request
    initial begin
        fill_valid = 1'b0;
        fill_data  = 8'h00;
        forever begin
            @(negedge clk);
            if (fetch_req) begin
                for (int i = 0; i < 528; i++) begin
                    fill_valid = 1'b1;
                    fill_data  = pat(int'(fetch_page), i);
                    @(negedge clk);
                end
                fill_valid = 1'b0;
            end
        end
    end

    task automatic do_cmd(input logic [7:0] b);
        bit take;
        @(negedge clk);
        take = (ce_n == 1'b0) && (busy == 1'b0);
        cmd_we   = 1'b1;
        cmd_byte = b;
        @(negedge clk);
        cmd_we = 1'b0;
        if (take) begin
            if (b == 8'h00) m_ptr = 0;
            else if (b == 8'h01) m_ptr = 1;
            else if (b == 8'h50) m_ptr = 2;
        end
    endtask

    task automatic do_addr(input logic [7:0] cb, input logic [15:0] pg);
        @(negedge clk);
        addr_we = 1'b1; addr_byte = cb;
        @(negedge clk);
        addr_byte = pg[7:0];
        @(negedge clk);
        addr_byte = pg[15:8];
        @(negedge clk);
        addr_we = 1'b0;
        m_spare = (m_ptr == 2);
        m_col   = m_start(m_ptr, int'(cb));
        m_page  = int'(pg);
        if (m_ptr == 1) m_ptr = 0;
        check("R4", "busy after address", 32'(busy), 32'd1);
        check("R4", "fetch_page", 32'(fetch_page), 32'(m_page));
        check("R8", "pointer after address", 32'(rd_ptr), 32'(m_ptr));
    endtask

    task automatic wait_ready();
        int t = 0;
        while (busy && t < 2000) begin
            @(negedge clk);
            t++;
        end
        check("R4", "busy released", 32'(busy), 32'd0);
        check("R4", "dout_valid after load", 32'(dout_valid), 32'd1);
        check("R2", "start column", 32'(rd_col), 32'(m_col));
    endtask

    task automatic read_n(input int n);
        for (int k = 0; k < n; k++) begin
            check("R5", "dout_valid", 32'(dout_valid), 32'd1);
            check("R5", "dout", 32'(dout), 32'(pat(m_page, m_col)));
            check("R5", "column", 32'(rd_col), 32'(m_col));
            re_pulse = 1'b1;
            @(negedge clk);
            re_pulse = 1'b0;
            if (m_col >= m_last(m_spare, so)) begin
                m_col  = m_spare ? 512 : 0;
                m_page = (m_page + 1) & 16'hFFFF;
                check("R6", "reload busy", 32'(busy), 32'd1);
                check("R6", "next page", 32'(fetch_page), 32'(m_page));
                wait_ready();
            end else begin
                m_col++;
            end
        end
    endtask

    task automatic re_once();
        re_pulse = 1'b1;
        @(negedge clk);
        re_pulse = 1'b0;
    endtask

    initial begin
        rst = 1'b1; ce_n = 1'b0; cmd_we = 1'b0; cmd_byte = 8'h00;
        addr_we = 1'b0; addr_byte = 8'h00; re_pulse = 1'b0; spare_off = 1'b0;
        void'($urandom(32'd20931));
        repeat (4) @(negedge clk);
        check("R11", "reset ptr", 32'(rd_ptr), 32'd0);
        check("R11", "reset busy", 32'(busy), 32'd0);
        check("R11", "reset fetch_req", 32'(fetch_req), 32'd0);
        check("R11", "reset dout_valid", 32'(dout_valid), 32'd0);
        rst = 1'b0;
        @(negedge clk);

        // first main half
        so = 1'b0; spare_off = 1'b0;
        do_cmd(8'h00);
        check("R1", "ptr 00h", 32'(rd_ptr), 32'd0);
        do_addr(8'h05, 16'h0010); wait_ready(); read_n(10);

        // second half, cross 511 into spare bytes, roll page
        do_cmd(8'h01);
        check("R1", "ptr 01h", 32'(rd_ptr), 32'd1);
        do_addr(8'hF0, 16'h0003); wait_ready(); read_n(34);

        // main read ending at 511 with spare_off high
        so = 1'b1; spare_off = 1'b1;
        do_cmd(8'h01);
        do_addr(8'hFE, 16'h0007); wait_ready(); read_n(4);

        // spare region, upper column bits ignored
        do_cmd(8'h50);
        check("R1", "ptr 50h", 32'(rd_ptr), 32'd2);
        do_addr(8'hA3, 16'h0009); wait_ready();
        check("R3", "spare start column", 32'(rd_col), 32'd515);
        read_n(30);
        check("R7", "spare kept across pages", 32'(rd_ptr), 32'd2);

        // re-address without command, wrap from last page
        do_addr(8'h02, 16'hFFFF); wait_ready(); read_n(15);
        check("R9", "page wrap", 32'(rd_page), 32'd0);
        check("R7", "spare kept after readdress", 32'(rd_ptr), 32'd2);

        // read strobes during load ignored
        so = 1'b0; spare_off = 1'b0;
        do_cmd(8'h00);
        check("R7", "00h leaves spare", 32'(rd_ptr), 32'd0);
        do_addr(8'h09, 16'h1234);
        re_once(); re_once();
        wait_ready();
        check("R4", "column untouched by strobes while busy", 32'(rd_col), 32'd9);
        read_n(3);

        // chip enable high ends the stream
        @(negedge clk);
        ce_n = 1'b1;
        @(negedge clk);
        check("R10", "dout_valid after ce_n", 32'(dout_valid), 32'd0);
        re_once();
        check("R10", "column frozen", 32'(rd_col), 32'(m_col));
        do_cmd(8'h50);
        check("R1", "command ignored with ce_n high", 32'(rd_ptr), 32'(m_ptr));
        ce_n = 1'b0;
        @(negedge clk);
        check("R10", "stays idle", 32'(dout_valid), 32'd0);

        // unknown command
        do_cmd(8'h80);
        check("R1", "unknown code ignored", 32'(rd_ptr), 32'(m_ptr));
        do_addr(8'h40, 16'h0101); wait_ready(); read_n(2);

        // random mix
        for (int it = 0; it < 40; it++) begin
            int op;
            logic [7:0] code;
            op = int'($urandom_range(0, 2));
            code = (op == 0) ? 8'h00 : ((op == 1) ? 8'h01 : 8'h50);
            so = ($urandom_range(0, 3) == 0);
            spare_off = so;
            do_cmd(code);
            check("R1", "random ptr", 32'(rd_ptr), 32'(m_ptr));
            do_addr(8'($urandom_range(0, 255)), 16'($urandom_range(0, 65535)));
            wait_ready();
            read_n(int'($urandom_range(1, 40)));
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule